// File: doc/BRIEF.md
# Modulo-M phase accumulator synthesizer

This block derives a slower clock from its input clock with an N-bit phase accumulator. The accumulator wraps at any modulus M up to 2^N, not only at a power of two. Every input clock the accumulator advances by a programmed step. On the cycle right after the binary adder carries out, the block also adds a correction equal to 2^N − M. The accumulator therefore behaves as a modulo-M counter, and the average output rate is exactly Fin·step/M.

The block has three outputs:
- A one-cycle tick marks each wrap.
- The accumulator's top bit gives a square wave.
- The top phase bits can address an external sine table.

A split mode divides the correction into two parts. The smaller half (rounded down) is added after the accumulator crosses its midpoint, and the rest is added after the wrap. Each half of the output period then covers M/2 of true phase, which keeps the duty cycle close to 50%.

Output edges carry up to one input-clock period of peak-to-peak jitter. This jitter is inherent to the method and is left alone. Step, correction and mode are captured in registers, so a new value acts one cycle after it is presented. The step must stay below M.

Top module: `modm_phase_synth`

## Requirements
- R1: When no correction is pending, each cycle the accumulator (visible on `phase_o` when PH_W = ACC_W) increases by the registered step modulo 2^ACC_W.
- R2: After a cycle whose addition carries out of ACC_W bits, `tick_o` is high for that one following cycle. The addition in that cycle is step + correction, where the correction is `corr_i` in wrap mode.
- R3: With ACC_W = 10, step 12 and correction 3 (M = 1021), any window of 1021 cycles that starts at a tick holds exactly 12 ticks, and the phase at the end of the window equals the phase at its start.
- R4: With ACC_W = 27 and correction 34,217,728 (M = 100,000,000), a step of F yields exactly F·C/100,000,000 ticks over C cycles whenever that product is an integer, and the phase repeats after C cycles.
- R5: `square_o` equals the accumulator's top bit and `phase_o` holds its top PH_W bits. For ACC_W = 10, step 1 and correction 24 in wrap mode, the square wave is high for 512 of every 1000 cycles.
- R6: With `split_duty_i` = 1, floor(corr/2) is added on the cycle after the top bit rises, and corr − floor(corr/2) is added on the cycle after a carry. For ACC_W = 10, step 1 and correction 24, the square wave is high for 500 of every 1000 cycles, with one tick per 1000 cycles.
- R7: A step of 0 with no pending correction leaves `phase_o`, `square_o` and `tick_o` unchanged.
- R8: A synchronous active-high reset clears the accumulator, the pending corrections, the registered configuration and `tick_o` to 0 at the next clock edge.
- R9: A value placed on `step_i` is captured at the first clock edge and first added at the second edge.
- R10: When the step is so large that a carry occurs in the same cycle that a pending correction is added (ACC_W = 10, step 999, correction 24), every carry still gets its own correction: 1000 cycles hold exactly 999 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | ACC_W | Phase step added every cycle (must be less than M) |
| corr_i | input | ACC_W | Modulus correction, 2^ACC_W − M |
| split_duty_i | input | 1 | 1: split the correction between midpoint and wrap |
| tick_o | output | 1 | One-cycle pulse on the cycle after each wrap |
| square_o | output | 1 | Accumulator top bit |
| phase_o | output | PH_W | Top PH_W accumulator bits for a sine table |

## Verification
The critical coincidence is a fresh carry in the same cycle that the previous carry's correction is being added. Both the pending-flag update and the enlarged increment act on that cycle. The bench provokes this with a step of 999 against a modulus of 1000, which makes carries nearly back-to-back. It judges the result by counting exactly 999 ticks in a 1000-cycle window and by finding the phase unchanged across the window. A lost or doubled correction would shift both the count and the phase.

// File: rtl/modm_pkg.sv
package modm_pkg;

  // Where the modulus correction is applied.
  typedef enum logic {
    CORR_AT_WRAP = 1'b0,  // whole correction after the carry
    CORR_SPLIT   = 1'b1   // half after the midpoint, rest after the carry
  } corr_mode_e;

  // Amount of correction added at the midpoint crossing.
  function automatic int unsigned low_share(input int unsigned corr, input corr_mode_e mode);
    return (mode == CORR_SPLIT) ? (corr >> 1) : 0;
  endfunction

endpackage

// File: rtl/modm_cfg_reg.sv
module modm_cfg_reg
  import modm_pkg::*;
#(
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_i,
  input  logic [ACC_W-1:0] corr_i,
  input  logic             split_i,
  output logic [ACC_W-1:0] step_q,
  output logic [ACC_W-1:0] corr_mid_q,
  output logic [ACC_W-1:0] corr_wrap_q,
  output logic             split_q
);

  corr_mode_e       mode_in;
  logic [ACC_W-1:0] mid_share;

  assign mode_in   = corr_mode_e'(split_i);
  assign mid_share = (mode_in == CORR_SPLIT) ? (corr_i >> 1) : '0;

  // Configuration is registered so a change lands between additions.
  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= '0;
      corr_mid_q  <= '0;
      corr_wrap_q <= '0;
      split_q     <= 1'b0;
    end else begin
      step_q      <= step_i;
      corr_mid_q  <= mid_share;
      corr_wrap_q <= corr_i - mid_share;
      split_q     <= (mode_in == CORR_SPLIT);
    end
  end

endmodule

// File: rtl/modm_phase_core.sv
module modm_phase_core #(
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_q,
  input  logic [ACC_W-1:0] corr_mid_q,
  input  logic [ACC_W-1:0] corr_wrap_q,
  input  logic             split_q,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_pend_o
);

  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q;
  logic             pend_full;
  logic             pend_half;
  logic [ACC_W:0]   incr;
  logic [ACC_W:0]   sum;
  logic             carry;
  logic             mid_cross;
  logic [ACC_W+1:0] cfg_total;
  logic             cfg_ok;

  // Step plus whichever correction the previous cycle scheduled.
  assign incr = {1'b0, step_q}
              + (pend_half ? {1'b0, corr_mid_q}  : '0)
              + (pend_full ? {1'b0, corr_wrap_q} : '0);
  assign sum       = {1'b0, acc_q} + incr;
  assign carry     = sum[ACC_W];
  assign mid_cross = split_q && !acc_q[MSB] && sum[MSB] && !carry;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      pend_full <= 1'b0;
      pend_half <= 1'b0;
    end else begin
      acc_q     <= sum[MSB:0];
      pend_full <= carry;
      pend_half <= mid_cross;
    end
  end

  assign acc_o       = acc_q;
  assign wrap_pend_o = pend_full;

  // Legal configuration: the largest increment stays below 2^ACC_W.
  assign cfg_total = {2'b00, step_q} + {2'b00, corr_mid_q} + {2'b00, corr_wrap_q};
  assign cfg_ok    = (cfg_total[ACC_W+1:ACC_W] == 2'b00);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !pend_full && !pend_half))
    else $error("R8: state not cleared by reset");

  a_r1_no_wrap_rises: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |=> (pend_full || acc_q >= $past(acc_q)))
    else $error("R1: phase fell without a carry");

  a_r2_wrap_falls: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |=> (!pend_full || acc_q < $past(acc_q)))
    else $error("R2: carry flagged without a phase wrap");

  a_r7_zero_step_holds: assert property (@(posedge clk) disable iff (rst)
    (step_q == '0 && !pend_full && !pend_half) |=> (acc_q == $past(acc_q)))
    else $error("R7: phase moved with zero step");

endmodule

// File: rtl/modm_out_tap.sv
module modm_out_tap #(
  parameter int ACC_W = 10,
  parameter int PH_W  = 4
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             wrap_pend_i,
  output logic [PH_W-1:0]  phase_o,
  output logic             square_o,
  output logic             tick_o
);

  localparam int MSB = ACC_W - 1;

  // All outputs come straight from flops in the core.
  generate
    if (PH_W == ACC_W) begin : g_full
      assign phase_o = acc_i;
    end else begin : g_top
      assign phase_o = acc_i[MSB -: PH_W];
    end
  endgenerate

  assign square_o = acc_i[MSB];
  assign tick_o   = wrap_pend_i;

endmodule

// File: rtl/modm_phase_synth.sv
module modm_phase_synth #(
  parameter int ACC_W = 10,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_i,
  input  logic [ACC_W-1:0] corr_i,
  input  logic             split_duty_i,
  output logic             tick_o,
  output logic             square_o,
  output logic [PH_W-1:0]  phase_o
);

  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] corr_mid_q;
  logic [ACC_W-1:0] corr_wrap_q;
  logic             split_q;
  logic [ACC_W-1:0] acc;
  logic             wrap_pend;

  modm_cfg_reg #(.ACC_W(ACC_W)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .step_i      (step_i),
    .corr_i      (corr_i),
    .split_i     (split_duty_i),
    .step_q      (step_q),
    .corr_mid_q  (corr_mid_q),
    .corr_wrap_q (corr_wrap_q),
    .split_q     (split_q)
  );

  modm_phase_core #(.ACC_W(ACC_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .step_q      (step_q),
    .corr_mid_q  (corr_mid_q),
    .corr_wrap_q (corr_wrap_q),
    .split_q     (split_q),
    .acc_o       (acc),
    .wrap_pend_o (wrap_pend)
  );

  modm_out_tap #(.ACC_W(ACC_W), .PH_W(PH_W)) u_out (
    .acc_i       (acc),
    .wrap_pend_i (wrap_pend),
    .phase_o     (phase_o),
    .square_o    (square_o),
    .tick_o      (tick_o)
  );

endmodule

// File: tb/tb_modm_phase_synth.sv
module tb_modm_phase_synth;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  step_a = '0, corr_a = '0;
  logic        split_a = 1'b0;
  logic        tick_a, sq_a;
  logic [9:0]  ph_a;
  logic [26:0] step_b = '0, corr_b = '0;
  logic        tick_b, sq_b;
  logic [3:0]  ph_b;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  modm_phase_synth #(.ACC_W(10), .PH_W(10)) dut (
    .clk(clk), .rst(rst), .step_i(step_a), .corr_i(corr_a),
    .split_duty_i(split_a), .tick_o(tick_a), .square_o(sq_a), .phase_o(ph_a));

  modm_phase_synth #(.ACC_W(27), .PH_W(4)) dut_w (
    .clk(clk), .rst(rst), .step_i(step_b), .corr_i(corr_b),
    .split_duty_i(1'b0), .tick_o(tick_b), .square_o(sq_b), .phase_o(ph_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  // Wait for a tick on the selected instance, then count over len cycles.
  task automatic window(input bit wide, input int len, output int cnt, output bit same);
    longint p0;
    while (!(wide ? tick_b : tick_a)) tick();
    p0  = wide ? ph_b : ph_a;
    cnt = 0;
    for (int i = 0; i < len; i++) begin
      tick();
      if (wide ? tick_b : tick_a) cnt++;
    end
    same = ((wide ? ph_b : ph_a) == p0);
  endtask

  task automatic t_reset();
    step_a = 10'd12; corr_a = 10'd3; split_a = 1'b0;
    rst = 1'b1;
    tick();
    chk(ph_a == 0 && !tick_a && !sq_a, "R8 reset state", ph_a, 0);
    rst = 1'b0;
    for (int i = 0; i < 100; i++) tick();
    rst = 1'b1;
    tick();
    chk(ph_a == 0 && !tick_a && !sq_a, "R8 mid-run reset", ph_a, 0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    step_a = '0; corr_a = '0; split_a = 1'b0;
    do_reset();
    tick(); tick();
    step_a = 10'd256;
    tick();
    chk(ph_a == 0, "R9 no change at load edge", ph_a, 0);
    tick();
    chk(ph_a == 256, "R9 step added on second edge", ph_a, 256);
  endtask

  task automatic t_advance();
    step_a = 10'd12; corr_a = '0; split_a = 1'b0;
    do_reset();
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk(ph_a == 12 * (k - 1), "R1 phase advance", ph_a, 12 * (k - 1));
    end
    for (int k = 9; k <= 50; k++) tick();
    chk(ph_a == 588 && sq_a == 1'b1, "R5 square follows top bit", {sq_a, ph_a}, 1024 + 588);
  endtask

  task automatic t_corr_pulse();
    longint prev, p0;
    step_a = 10'd12; corr_a = 10'd3; split_a = 1'b0;
    do_reset();
    prev = ph_a;
    tick();
    while (!tick_a) begin
      prev = ph_a;
      tick();
    end
    p0 = ph_a;
    chk(prev + 12 >= 1024 && p0 == prev + 12 - 1024, "R2 wrap value", p0, prev + 12 - 1024);
    tick();
    chk(!tick_a, "R2 tick lasts one cycle", tick_a, 0);
    chk(ph_a == ((p0 + 15) % 1024), "R2 corrected increment", ph_a, (p0 + 15) % 1024);
  endtask

  task automatic t_period();
    int cnt; bit same;
    step_a = 10'd12; corr_a = 10'd3; split_a = 1'b0;
    do_reset();
    window(1'b0, 1021, cnt, same);
    chk(cnt == 12, "R3 ticks per 1021 cycles", cnt, 12);
    chk(same, "R3 phase returns", same, 1);
  endtask

  task automatic t_backtoback();
    int cnt; bit same;
    step_a = 10'd999; corr_a = 10'd24; split_a = 1'b0;
    do_reset();
    window(1'b0, 1000, cnt, same);
    chk(cnt == 999, "R10 carry during pending correction", cnt, 999);
    chk(same, "R10 phase returns", same, 1);
  endtask

  task automatic t_hold();
    bit ok;
    longint p;
    step_a = '0; corr_a = 10'd3; split_a = 1'b0;
    do_reset();
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (ph_a != 0 || tick_a || sq_a) ok = 1'b0;
    end
    chk(ok, "R7 zero step from reset", ph_a, 0);
    step_a = 10'd12;
    for (int i = 0; i < 200; i++) tick();
    step_a = '0;
    tick(); tick(); tick();
    p = ph_a;
    ok = 1'b1;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (ph_a != p || tick_a) ok = 1'b0;
    end
    chk(ok, "R7 zero step after running", ph_a, p);
  endtask

  task automatic t_duty(input bit split, input int exp_hi, input string req);
    int hi, ticks;
    step_a = 10'd1; corr_a = 10'd24; split_a = split;
    do_reset();
    for (int i = 0; i < 1100; i++) tick();
    hi = 0; ticks = 0;
    for (int i = 0; i < 1000; i++) begin
      tick();
      if (sq_a) hi++;
      if (tick_a) ticks++;
    end
    chk(hi == exp_hi, req, hi, exp_hi);
    chk(ticks == 1, req, ticks, 1);
  endtask

  task automatic t_hz(input int f, input int len, input int exp_cnt);
    int cnt; bit same;
    step_b = 27'(f); corr_b = 27'd34217728;
    do_reset();
    window(1'b1, len, cnt, same);
    chk(cnt == exp_cnt, "R4 exact integer-Hz tick count", cnt, exp_cnt);
    chk(same, "R4 phase repeats", same, 1);
    step_b = '0;
  endtask

  initial begin
    #(CLK_P * 180000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_advance();
    t_corr_pulse();
    t_period();
    t_backtoback();
    t_hold();
    t_duty(1'b0, 512, "R5 wrap-mode duty");
    t_duty(1'b1, 500, "R6 split-mode duty");
    t_hz(25000000, 400, 100);
    t_hz(1000000, 1000, 10);
    t_hz(1234375, 6400, 79);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule